// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block is the part of an I2C master that owns the bus framing. It watches the SDA and SCL wires and keeps a flag that is high from the moment any master opens a transfer until that transfer is closed. Software can also tell the block to open a transfer, reopen it without letting go of the bus, or close it. The block then drives the matching condition onto two open-drain outputs and times each phase with a programmable SCL half-period.

All control goes through one byte-wide register on a simple synchronous write port. The read port is combinational. One bit is both the occupancy flag and the command bit. A companion bit gates every write and always reads back as one. Two read-only bits report whether SDA and SCL are being driven low. A sticky flag records a start that was refused. A self-clearing bit returns the condition logic to its idle state after a bus hang.

Top module: `i2c_cond_unit`

## Requirements
- R1: Register bit 7 (busy) becomes 1 once the synchronised SDA falls while the synchronised SCL is high. This holds whichever master caused the edge.
- R2: Busy returns to 0 once the synchronised SDA rises while the synchronised SCL is high.
- R3: A write with bit 6 = 0, bit 1 = 0 and bit 7 = 1 starts a transfer, provided the controller is idle and busy is 0. SDA is driven low while SCL stays released for div_half+1 clocks. After that both lines are held low until the next command.
- R4: The same write issued while this controller holds the bus performs a repeated start. SDA is released with SCL low for div_half+1 clocks. Then both lines are released for div_half+1 clocks. Then the R3 start phase follows.
- R5: A write with bit 6 = 0, bit 1 = 0 and bit 7 = 0 issued while the bus is held performs a stop. Both lines stay low for div_half+1 clocks. Then SCL is released for div_half+1 clocks. Then both lines are released.
- R6: A write with bit 6 = 1 changes nothing. Bit 6 always reads 1. Reserved bits 4 and 2 always read 1 and ignore writes.
- R7: Bit 5 reads 0 while SDA is driven low and 1 while it is released. Bit 3 reports SCL in the same way.
- R8: A start request while busy is 1 and the controller is idle is refused. It sets bit 0 (error), which stays 1 until a control reset.
- R9: A write with bit 6 = 0 and bit 1 = 1 is a control reset. It takes priority over the bit 7 command. Bit 1 reads 1 for exactly one clock and then clears. Both lines are released from the next clock. Busy and error are cleared, and the controller returns to idle.
- R10: After reset the register reads 0x7C and both lines are released.
- R11: A command written while a condition sequence is in progress is ignored. A stop written while the controller does not hold the bus is ignored. Neither sets the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Control byte written |
| reg_rdata | output | 8 | Control byte read back (combinational) |
| div_half | input | DIV_W | SCL half-period minus one, in clocks |
| sda_in | input | 1 | Sampled SDA wire level |
| scl_in | input | 1 | Sampled SCL wire level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |

## Verification
A wrong sequencer state or phase counter shows on sda_oe and scl_oe in the same clock it goes wrong. It also shows on the monitor bits of the read port in that clock. The reference model compares both every cycle, so a phase that is one clock short or long is caught at once. A fault in the synchroniser or edge detector shows on the busy bit. That bit is expected exactly three clocks after the wire edge, so a missing, extra or late stage is reported at that point. A lost error or control-reset bit is seen on the next read.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int REG_W  = 8;
    localparam int B_BUSY = 7;
    localparam int B_QUAL = 6;
    localparam int B_SDAM = 5;
    localparam int B_SCLM = 3;
    localparam int B_CRST = 1;
    localparam int B_ERR  = 0;
    localparam logic [REG_W-1:0] READ_ONES = 8'h54;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STA,
        SQ_OWN,
        SQ_RSA,
        SQ_RSB,
        SQ_STP_A,
        SQ_STP_B
    } seq_state_t;

    typedef struct packed {
        logic want_start;
        logic want_stop;
        logic want_clr;
    } cmd_t;

    typedef struct packed {
        logic busy;
        logic sda_drv;
        logic scl_drv;
        logic crst;
        logic err;
    } view_t;

    function automatic cmd_t decode_write(input logic wr, input logic [REG_W-1:0] d);
        cmd_t c;
        logic live;
        live         = wr & ~d[B_QUAL];
        c.want_clr   = live & d[B_CRST];
        c.want_start = live & ~d[B_CRST] & d[B_BUSY];
        c.want_stop  = live & ~d[B_CRST] & ~d[B_BUSY];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_view(input view_t v);
        logic [REG_W-1:0] r;
        r         = READ_ONES;
        r[B_BUSY] = v.busy;
        r[B_SDAM] = ~v.sda_drv;
        r[B_SCLM] = ~v.scl_drv;
        r[B_CRST] = v.crst;
        r[B_ERR]  = v.err;
        return r;
    endfunction

endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sda_in,
    input  logic scl_in,
    output logic busy
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic             sda_prev;
    logic             start_ev;
    logic             stop_ev;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [SYNC_N-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[SYNC_N-2:0], raw[g]};
        end
        assign lvl[g] = chain[SYNC_N-1];
    end

    always_ff @(posedge clk) begin
        if (rst) sda_prev <= 1'b1;
        else     sda_prev <= lvl[0];
    end

    assign start_ev = sda_prev & ~lvl[0] & lvl[1];
    assign stop_ev  = ~sda_prev & lvl[0] & lvl[1];

    always_ff @(posedge clk) begin
        if (rst || clr)    busy <= 1'b0;
        else if (start_ev) busy <= 1'b1;
        else if (stop_ev)  busy <= 1'b0;
    end

    assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (start_ev && !clr) |=> busy);

    assert_stop_clears_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (stop_ev && !clr) |=> !busy);

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             bus_busy,
    input  logic [DIV_W-1:0] div_half,
    output seq_state_t       phase,
    output logic             sda_drv,
    output logic             scl_drv,
    output logic             refused
);
    seq_state_t       st_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic             last;

    assign last = (cnt == div_half);

    always_comb begin
        st_n  = phase;
        cnt_n = cnt + DIV_W'(1);
        case (phase)
            SQ_IDLE: begin
                cnt_n = '0;
                if (start_req && !bus_busy) st_n = SQ_STA;
            end
            SQ_OWN: begin
                cnt_n = '0;
                if (start_req)     st_n = SQ_RSA;
                else if (stop_req) st_n = SQ_STP_A;
            end
            SQ_STA:   if (last) begin st_n = SQ_OWN;   cnt_n = '0; end
            SQ_RSA:   if (last) begin st_n = SQ_RSB;   cnt_n = '0; end
            SQ_RSB:   if (last) begin st_n = SQ_STA;   cnt_n = '0; end
            SQ_STP_A: if (last) begin st_n = SQ_STP_B; cnt_n = '0; end
            SQ_STP_B: if (last) begin st_n = SQ_IDLE;  cnt_n = '0; end
            default: begin st_n = SQ_IDLE; cnt_n = '0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            phase <= st_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        case (phase)
            SQ_STA:   {sda_drv, scl_drv} = 2'b10;
            SQ_OWN:   {sda_drv, scl_drv} = 2'b11;
            SQ_RSA:   {sda_drv, scl_drv} = 2'b01;
            SQ_STP_A: {sda_drv, scl_drv} = 2'b11;
            SQ_STP_B: {sda_drv, scl_drv} = 2'b10;
            default:  {sda_drv, scl_drv} = 2'b00;
        endcase
    end

    assign refused = start_req && bus_busy && (phase == SQ_IDLE);

    assert_busy_phase_cmd_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        ((phase == SQ_STA) && !last && !clr) |=> (phase == SQ_STA));

endmodule

// File: rtl/i2c_cond_unit.sv
module i2c_cond_unit
    import i2c_cond_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [DIV_W-1:0] div_half,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_oe,
    output logic             scl_oe
);
    cmd_t       cmd;
    view_t      view;
    seq_state_t phase;
    logic       crst_q, err_q, clr, busy;
    logic       gen_sda, gen_scl, refused;

    assign cmd = decode_write(reg_wr, reg_wdata);
    assign clr = cmd.want_clr | crst_q;

    always_ff @(posedge clk) begin
        if (rst) crst_q <= 1'b0;
        else     crst_q <= cmd.want_clr;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)   err_q <= 1'b0;
        else if (refused) err_q <= 1'b1;
    end

    i2c_line_watch #(.SYNC_N(SYNC_N)) u_watch (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .sda_in (sda_in),
        .scl_in (scl_in),
        .busy   (busy)
    );

    i2c_cond_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .start_req (cmd.want_start),
        .stop_req  (cmd.want_stop),
        .bus_busy  (busy),
        .div_half  (div_half),
        .phase     (phase),
        .sda_drv   (gen_sda),
        .scl_drv   (gen_scl),
        .refused   (refused)
    );

    assign sda_oe = gen_sda & ~crst_q;
    assign scl_oe = gen_scl & ~crst_q;

    assign view.busy    = busy;
    assign view.sda_drv = sda_oe;
    assign view.scl_drv = scl_oe;
    assign view.crst    = crst_q;
    assign view.err     = err_q;
    assign reg_rdata    = pack_view(view);

    assert_start_edge_shape_R3: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> (phase == SQ_STA));

    assert_stop_edge_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> (phase == SQ_IDLE));

    assert_qual_write_inert_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[B_QUAL] && (phase == SQ_IDLE) && !crst_q) |=> (phase == SQ_IDLE));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr) |=> err_q);

    assert_crst_self_clear_R9: assert property (@(posedge clk) disable iff (rst)
        crst_q |=> (!crst_q || $past(cmd.want_clr)));

    assert_crst_releases_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cmd.want_clr) |-> (!sda_oe && !scl_oe));

endmodule

// File: tb/sim_i2c_cond_unit.sv
module sim_i2c_cond_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] div_half;
    logic       ext_sda, ext_scl;
    logic       sda_oe, scl_oe;
    wire        sda_line = ~(sda_oe | ext_sda);
    wire        scl_line = ~(scl_oe | ext_scl);

    always #5 clk = ~clk;

    i2c_cond_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .div_half  (div_half),
        .sda_in    (sda_line),
        .scl_in    (scl_line),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R10";

    // reference model: queue of {sda_drive, scl_drive} per clock, resting level after it
    logic [1:0] mq[$];
    logic [1:0] rest;
    logic       m_busy, m_err, m_crst;
    logic [3:1] hs, hc;

    function automatic logic [1:0] m_out();
        if (m_crst)          return 2'b00;
        if (mq.size() != 0)  return mq[0];
        return rest;
    endfunction

    task automatic push_phase(input logic [1:0] v);
        for (int i = 0; i <= int'(div_half); i++) mq.push_back(v);
    endtask

    always @(posedge clk) begin : model
        logic [1:0] o;
        logic ls, lc, live, w_clr, w_sta, w_sto, clr, was_idle, old_busy;
        if (rst) begin
            mq.delete();
            rest = 2'b00; m_busy = 0; m_err = 0; m_crst = 0; hs = '1; hc = '1;
        end else begin
            o        = m_out();
            ls       = !(o[1] | ext_sda);
            lc       = !(o[0] | ext_scl);
            live     = reg_wr && !reg_wdata[6];
            w_clr    = live && reg_wdata[1];
            w_sta    = live && !reg_wdata[1] && reg_wdata[7];
            w_sto    = live && !reg_wdata[1] && !reg_wdata[7];
            clr      = w_clr || m_crst;
            old_busy = m_busy;
            was_idle = (mq.size() == 0);
            if (clr)                              m_busy = 0;
            else if (hs[3] && !hs[2] && hc[2])    m_busy = 1;
            else if (!hs[3] && hs[2] && hc[2])    m_busy = 0;
            hs = {hs[2], hs[1], ls};
            hc = {hc[2], hc[1], lc};
            if (clr) begin
                mq.delete();
                rest = 2'b00; m_err = 0;
            end else begin
                if (mq.size() != 0) void'(mq.pop_front());
                if (w_sta && was_idle) begin
                    if (rest == 2'b11) begin
                        push_phase(2'b01); push_phase(2'b00); push_phase(2'b10);
                    end else if (!old_busy) begin
                        push_phase(2'b10); rest = 2'b11;
                    end else begin
                        m_err = 1;
                    end
                end else if (w_sto && was_idle && rest == 2'b11) begin
                    push_phase(2'b11); push_phase(2'b10); rest = 2'b00;
                end
            end
            m_crst = w_clr;
        end
    end

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [1:0] o;
        if (!rst) begin
            o = m_out();
            chk({tag, " lines vs model"}, {6'd0, sda_oe, scl_oe}, {6'd0, o});
            chk({tag, " register vs model"}, reg_rdata,
                {m_busy, 1'b1, ~o[1], 1'b1, ~o[0], 1'b1, m_crst, m_err});
        end
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1; reg_wr = 0; reg_wdata = 0; ext_sda = 0; ext_scl = 0; div_half = 8'd3;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R10 reset value", reg_rdata, 8'h7C);
        chk("R10 reset lines", {6'd0, sda_oe, scl_oe}, 8'h00);

        tag = "R6";
        wr(8'hC2); idle(3);
        chk("R6 qualified write inert", reg_rdata, 8'h7C);
        tag = "R11";
        wr(8'h3D); idle(3);
        chk("R11 stop while idle, R6 reserved bits", reg_rdata, 8'h7C);

        tag = "R3";
        wr(8'h80);
        chk("R3 start phase lines", {6'd0, sda_oe, scl_oe}, 8'h02);
        chk("R7 monitors during start", reg_rdata, 8'h5C);
        idle(12);
        chk("R3 held after start", {6'd0, sda_oe, scl_oe}, 8'h03);
        chk("R1 busy after own start", reg_rdata, 8'hD4);

        tag = "R4";
        wr(8'h80);
        chk("R4 release SDA first", {6'd0, sda_oe, scl_oe}, 8'h01);
        idle(4);
        chk("R4 both released", {6'd0, sda_oe, scl_oe}, 8'h00);
        idle(4);
        chk("R4 start phase again", {6'd0, sda_oe, scl_oe}, 8'h02);
        idle(8);
        chk("R4 held and busy", reg_rdata, 8'hD4);

        tag = "R5";
        wr(8'h00);
        chk("R5 stop first phase", {6'd0, sda_oe, scl_oe}, 8'h03);
        tag = "R11";
        wr(8'h00);
        wr(8'h80);
        tag = "R5";
        idle(10);
        chk("R5 R2 released and free, R11 no error", reg_rdata, 8'h7C);

        tag = "R8";
        ext_sda = 1; idle(5);
        chk("R1 foreign start seen", reg_rdata, 8'hFC);
        wr(8'h80); idle(2);
        chk("R8 refused start sets error", reg_rdata, 8'hFD);
        ext_sda = 0; idle(5);
        chk("R2 foreign stop, R8 error sticky", reg_rdata, 8'h7D);

        tag = "R9";
        wr(8'h02);
        chk("R9 control reset visible", reg_rdata, 8'h7E);
        idle(1);
        chk("R9 self-clear", reg_rdata, 8'h7C);
        wr(8'h80); idle(10);
        chk("R9 owned before reset", {6'd0, sda_oe, scl_oe}, 8'h03);
        wr(8'h82);
        chk("R9 reset releases lines", {6'd0, sda_oe, scl_oe}, 8'h00);
        chk("R9 reset clears busy", reg_rdata, 8'h7E);
        idle(10);
        chk("R9 idle after reset", reg_rdata, 8'h7C);

        tag = "R3";
        div_half = 8'd0;
        wr(8'h80);
        chk("R3 short start phase", {6'd0, sda_oe, scl_oe}, 8'h02);
        idle(1);
        chk("R3 short hold", {6'd0, sda_oe, scl_oe}, 8'h03);
        idle(4);
        chk("R1 busy short", reg_rdata, 8'hD4);
        tag = "R5";
        wr(8'h00);
        chk("R5 short stop a", {6'd0, sda_oe, scl_oe}, 8'h03);
        idle(1);
        chk("R5 short stop b", {6'd0, sda_oe, scl_oe}, 8'h02);
        idle(1);
        chk("R5 short released", {6'd0, sda_oe, scl_oe}, 8'h00);
        idle(5);
        chk("R2 short free", reg_rdata, 8'h7C);

        finish_run();
    end
endmodule